// File: doc/BRIEF.md
# Auxiliary Signal OR-Crossbar

This block builds eight auxiliary signals for a downstream configurable logic block. It draws from a fixed field of 128 source wires, arranged as 32 groups of four. Each output owns a bank of 32 four-way selectors. Every selector has its own enable and a two-bit choice of which wire in its group it passes. The enabled selector results are ORed together, an optional per-output invert is applied, and the result is captured in a flop that drives the output pin.

Software-style configuration uses two write strobes with address fields.

- The selector port addresses one selector in one bank and writes its enable and its choice.
- The control port addresses one output. It writes that output's invert bit and can issue a one-shot clear of the whole bank.

A combinational readback port shows the enable mask and the packed choices of any bank. Some source positions are reserved: they read as 0 even when selected.

Top module: `aux_or_xbar`

## Requirements
- R1: While `rst` is high at a clock edge, all enables, choices and invert bits clear. After that edge, `aux_o` is 0 and every bank reads back an enable mask of 0 and choices of 0.
- R2: A selector write stores `cfg_wdata[2]` as the enable and `cfg_wdata[1:0]` as the choice. The write goes to selector `cfg_mux` of bank `cfg_out`. The change is visible on the readback of that bank after the write edge. The readback places choice m at `rb_sel_o[2m+1:2m]` and enable m at `rb_en_o[m]`. No other selector changes.
- R3: An enabled selector m with choice k passes source bit `src_i[4m+k]`.
- R4: Before inversion, output o is the OR of the passed bits of all enabled selectors of bank o.
- R5: When every selector of a bank is disabled, that output is 0 before inversion, whatever the sources are.
- R6: A control write stores `ctl_wdata[0]` as the invert bit of output `ctl_out`. When that bit is set, the output is the complement of its OR result.
- R7: A control write with `ctl_wdata[1]` set clears all 32 enables and choices of bank `ctl_out`, and the invert bit is written as in R6. Other banks keep their settings. The clear bit is not stored, so a later control write without it clears nothing. A clear beats a selector write to the same bank in the same cycle.
- R8: The reserved source positions read as 0 even when selected. These are selector 19 choice 3 and selector 21 choice 3.
- R9: A change on `src_i` reaches `aux_o` at the next clock edge. A configuration write reaches `aux_o` at the edge after the write edge.
- R10: The eight outputs are independent, and `rb_out` picks which bank the readback shows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_i | input | 128 | Source wires, selector m choice k at bit 4m+k |
| cfg_we | input | 1 | Selector write strobe |
| cfg_out | input | 3 | Bank index for selector write |
| cfg_mux | input | 5 | Selector index for selector write |
| cfg_wdata | input | 3 | Bit 2 enable, bits 1:0 choice |
| ctl_we | input | 1 | Control write strobe |
| ctl_out | input | 3 | Output index for control write |
| ctl_wdata | input | 2 | Bit 0 invert, bit 1 one-shot bank clear |
| rb_out | input | 3 | Bank shown on readback |
| rb_en_o | output | 32 | Enable mask of the chosen bank |
| rb_sel_o | output | 64 | Packed choices of the chosen bank |
| aux_o | output | 8 | Registered auxiliary outputs |

## Verification
A corrupted enable or choice in a bank shows up as a wrong readback right after the write edge. It also shows as a wrong `aux_o` bit one edge later, once a source under that selector toggles. A stuck invert bit flips its output on the very next edge, even with the bank empty. A clear that leaks into another bank, or that persists, is seen on the readback of the neighbouring bank and on the following write. A reserved position that leaks through drives its output high one edge after the sources go all-ones.

// File: rtl/aux_xbar_pkg.sv
package aux_xbar_pkg;
  // control word layout
  typedef struct packed {
    logic clr;
    logic inv;
  } ctl_word_t;

  localparam int unsigned XB_OUTS  = 8;
  localparam int unsigned XB_MUXES = 32;
  localparam int unsigned XB_INS   = 4;
endpackage

// File: rtl/aux_cfg_bank.sv
module aux_cfg_bank #(
  parameter int unsigned N_MUX = 32,
  parameter int unsigned SEL_W = 2,
  localparam int unsigned MUX_W = $clog2(N_MUX)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr,
  input  logic [MUX_W-1:0]       wr_mux,
  input  logic                   wr_en_bit,
  input  logic [SEL_W-1:0]       wr_sel,
  input  logic                   ctl_wr,
  input  logic                   ctl_inv,
  input  logic                   clr,
  output logic [N_MUX-1:0]       en_mask,
  output logic [N_MUX*SEL_W-1:0] sel_flat,
  output logic                   inv
);
  logic [N_MUX-1:0] en_q;
  logic [SEL_W-1:0] sel_q [N_MUX];
  logic             inv_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= '0;
      inv_q <= 1'b0;
      for (int m = 0; m < N_MUX; m++) sel_q[m] <= '0;
    end else begin
      if (ctl_wr) inv_q <= ctl_inv;
      if (clr) begin
        en_q <= '0;
        for (int m = 0; m < N_MUX; m++) sel_q[m] <= '0;
      end else if (wr) begin
        en_q[wr_mux]  <= wr_en_bit;
        sel_q[wr_mux] <= wr_sel;
      end
    end
  end

  assign en_mask = en_q;
  assign inv     = inv_q;

  for (genvar m = 0; m < N_MUX; m++) begin : g_pack
    assign sel_flat[m*SEL_W +: SEL_W] = sel_q[m];
  end
endmodule

// File: rtl/aux_sel_or.sv
module aux_sel_or #(
  parameter int unsigned N_MUX = 32,
  parameter int unsigned N_IN  = 4,
  parameter int unsigned SEL_W = 2
) (
  input  logic [N_MUX*N_IN-1:0]  src,
  input  logic [N_MUX-1:0]       en_mask,
  input  logic [N_MUX*SEL_W-1:0] sel_flat,
  output logic                   raw
);
  // base position of group m in the source field
  function automatic int unsigned grp_base(input int unsigned m);
    return m * N_IN;
  endfunction

  logic [N_MUX-1:0] pass;

  for (genvar m = 0; m < N_MUX; m++) begin : g_mux
    logic [N_IN-1:0]  grp;
    logic [SEL_W-1:0] sel;
    assign grp     = src[grp_base(m) +: N_IN];
    assign sel     = sel_flat[m*SEL_W +: SEL_W];
    assign pass[m] = en_mask[m] & grp[sel];
  end

  assign raw = |pass;
endmodule

// File: rtl/aux_or_xbar.sv
module aux_or_xbar
  import aux_xbar_pkg::*;
#(
  parameter int unsigned N_OUT = XB_OUTS,
  parameter int unsigned N_MUX = XB_MUXES,
  parameter int unsigned N_IN  = XB_INS,
  localparam int unsigned SEL_W = $clog2(N_IN),
  localparam int unsigned OUT_W = $clog2(N_OUT),
  localparam int unsigned MUX_W = $clog2(N_MUX),
  localparam int unsigned SRC_W = N_MUX * N_IN,
  parameter logic [SRC_W-1:0] RSV_MASK = (SRC_W'(1) << 79) | (SRC_W'(1) << 87)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [SRC_W-1:0]       src_i,
  input  logic                   cfg_we,
  input  logic [OUT_W-1:0]       cfg_out,
  input  logic [MUX_W-1:0]       cfg_mux,
  input  logic [SEL_W:0]         cfg_wdata,
  input  logic                   ctl_we,
  input  logic [OUT_W-1:0]       ctl_out,
  input  logic [1:0]             ctl_wdata,
  input  logic [OUT_W-1:0]       rb_out,
  output logic [N_MUX-1:0]       rb_en_o,
  output logic [N_MUX*SEL_W-1:0] rb_sel_o,
  output logic [N_OUT-1:0]       aux_o
);
  ctl_word_t ctl_w;
  assign ctl_w = ctl_word_t'(ctl_wdata);

  // reserved positions are forced low once, before any selection
  logic [SRC_W-1:0] src_live;
  assign src_live = src_i & ~RSV_MASK;

  logic [N_MUX-1:0]       en_all  [N_OUT];
  logic [N_MUX*SEL_W-1:0] sel_all [N_OUT];

  // named internal events for the checker
  logic [N_OUT*N_MUX-1:0] en_flat;
  logic [N_OUT-1:0]       inv_vec;
  logic [N_OUT-1:0]       raw_vec;
  logic [N_OUT-1:0]       clr_vec;
  logic [N_OUT-1:0]       aux_q;

  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    logic hit_cfg, hit_ctl;
    assign hit_cfg    = cfg_we && (cfg_out == OUT_W'(o));
    assign hit_ctl    = ctl_we && (ctl_out == OUT_W'(o));
    assign clr_vec[o] = hit_ctl && ctl_w.clr;

    aux_cfg_bank #(.N_MUX(N_MUX), .SEL_W(SEL_W)) u_bank (
      .clk       (clk),
      .rst       (rst),
      .wr        (hit_cfg),
      .wr_mux    (cfg_mux),
      .wr_en_bit (cfg_wdata[SEL_W]),
      .wr_sel    (cfg_wdata[SEL_W-1:0]),
      .ctl_wr    (hit_ctl),
      .ctl_inv   (ctl_w.inv),
      .clr       (clr_vec[o]),
      .en_mask   (en_all[o]),
      .sel_flat  (sel_all[o]),
      .inv       (inv_vec[o])
    );

    aux_sel_or #(.N_MUX(N_MUX), .N_IN(N_IN), .SEL_W(SEL_W)) u_or (
      .src      (src_live),
      .en_mask  (en_all[o]),
      .sel_flat (sel_all[o]),
      .raw      (raw_vec[o])
    );

    assign en_flat[o*N_MUX +: N_MUX] = en_all[o];
  end

  always_ff @(posedge clk) begin
    if (rst) aux_q <= '0;
    else     aux_q <= raw_vec ^ inv_vec;
  end

  assign aux_o    = aux_q;
  assign rb_en_o  = en_all[rb_out];
  assign rb_sel_o = sel_all[rb_out];
endmodule

// File: rtl/aux_or_xbar_chk.sv
module aux_or_xbar_chk #(
  parameter int unsigned N_OUT = 8,
  parameter int unsigned N_MUX = 32,
  parameter int unsigned OUT_W = 3,
  parameter int unsigned MUX_W = 5,
  parameter int unsigned SEL_W = 2
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   cfg_we,
  input logic [OUT_W-1:0]       cfg_out,
  input logic [MUX_W-1:0]       cfg_mux,
  input logic [SEL_W:0]         cfg_wdata,
  input logic                   ctl_we,
  input logic [OUT_W-1:0]       ctl_out,
  input logic [1:0]             ctl_wdata,
  input logic [N_OUT*N_MUX-1:0] en_flat,
  input logic [N_OUT-1:0]       inv_vec,
  input logic [N_OUT-1:0]       raw_vec,
  input logic [N_OUT-1:0]       aux_o
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (aux_o == '0) && (en_flat == '0) && (inv_vec == '0));

  for (genvar o = 0; o < N_OUT; o++) begin : g_chk
    // R5
    empty_bank_chk: assert property (@(posedge clk) disable iff (rst)
      (en_flat[o*N_MUX +: N_MUX] == '0) |=> aux_o[o] == $past(inv_vec[o]));

    // R9
    out_latency_chk: assert property (@(posedge clk) disable iff (rst)
      !$fell(rst) |-> aux_o[o] == ($past(raw_vec[o]) ^ $past(inv_vec[o])));

    // R7
    bank_clear_chk: assert property (@(posedge clk) disable iff (rst)
      (ctl_we && ctl_out == OUT_W'(o) && ctl_wdata[1]) |=> en_flat[o*N_MUX +: N_MUX] == '0);

    // R2
    sel_write_chk: assert property (@(posedge clk) disable iff (rst)
      (cfg_we && cfg_out == OUT_W'(o) && !(ctl_we && ctl_out == OUT_W'(o) && ctl_wdata[1]))
      |=> en_flat[o*N_MUX + int'($past(cfg_mux))] == $past(cfg_wdata[SEL_W]));

    // R6
    inv_write_chk: assert property (@(posedge clk) disable iff (rst)
      (ctl_we && ctl_out == OUT_W'(o)) |=> inv_vec[o] == $past(ctl_wdata[0]));
  end
endmodule

bind aux_or_xbar aux_or_xbar_chk #(
  .N_OUT(N_OUT), .N_MUX(N_MUX), .OUT_W(OUT_W), .MUX_W(MUX_W), .SEL_W(SEL_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cfg_we    (cfg_we),
  .cfg_out   (cfg_out),
  .cfg_mux   (cfg_mux),
  .cfg_wdata (cfg_wdata),
  .ctl_we    (ctl_we),
  .ctl_out   (ctl_out),
  .ctl_wdata (ctl_wdata),
  .en_flat   (en_flat),
  .inv_vec   (inv_vec),
  .raw_vec   (raw_vec),
  .aux_o     (aux_o)
);

// File: tb/tb_aux_or_xbar.sv
module tb_aux_or_xbar;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [127:0] src_i = '0;
  logic         cfg_we = 1'b0;
  logic [2:0]   cfg_out = '0;
  logic [4:0]   cfg_mux = '0;
  logic [2:0]   cfg_wdata = '0;
  logic         ctl_we = 1'b0;
  logic [2:0]   ctl_out = '0;
  logic [1:0]   ctl_wdata = '0;
  logic [2:0]   rb_out = '0;
  logic [31:0]  rb_en_o;
  logic [63:0]  rb_sel_o;
  logic [7:0]   aux_o;

  int checks = 0;
  int failures = 0;

  bit m_en  [8][32];
  int m_sel [8][32];
  bit m_inv [8];

  always #10 clk = ~clk;

  aux_or_xbar dut (
    .clk(clk), .rst(rst), .src_i(src_i),
    .cfg_we(cfg_we), .cfg_out(cfg_out), .cfg_mux(cfg_mux), .cfg_wdata(cfg_wdata),
    .ctl_we(ctl_we), .ctl_out(ctl_out), .ctl_wdata(ctl_wdata),
    .rb_out(rb_out), .rb_en_o(rb_en_o), .rb_sel_o(rb_sel_o), .aux_o(aux_o)
  );

  function automatic bit is_rsv(int m, int k);
    return (m == 19 && k == 3) || (m == 21 && k == 3);
  endfunction

  function automatic logic [7:0] model_aux();
    logic [7:0] v;
    for (int o = 0; o < 8; o++) begin
      bit r = 1'b0;
      for (int m = 0; m < 32; m++)
        if (m_en[o][m] && !is_rsv(m, m_sel[o][m]) && src_i[m*4 + m_sel[o][m]]) r = 1'b1;
      v[o] = r ^ m_inv[o];
    end
    return v;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic cfg_wr(input int o, input int m, input bit en, input int sel);
    @(negedge clk);
    cfg_we = 1'b1; cfg_out = 3'(o); cfg_mux = 5'(m); cfg_wdata = {en, 2'(sel)};
    @(negedge clk);
    cfg_we = 1'b0;
    m_en[o][m] = en; m_sel[o][m] = sel;
  endtask

  task automatic ctl_wr(input int o, input bit inv, input bit clr);
    @(negedge clk);
    ctl_we = 1'b1; ctl_out = 3'(o); ctl_wdata = {clr, inv};
    @(negedge clk);
    ctl_we = 1'b0;
    m_inv[o] = inv;
    if (clr) for (int m = 0; m < 32; m++) begin m_en[o][m] = 0; m_sel[o][m] = 0; end
  endtask

  task automatic chk_aux(input string tag);
    logic [7:0] e = model_aux();
    chk(aux_o === e, tag, 64'(aux_o), 64'(e));
  endtask

  task automatic t_reset();
    src_i = '1;
    step();
    chk(aux_o === 8'h00, "R1 aux after reset", 64'(aux_o), 0);
    for (int o = 0; o < 8; o++) begin
      rb_out = 3'(o); #1;
      chk(rb_en_o === '0 && rb_sel_o === '0, "R1 readback after reset", 64'(rb_en_o), 0);
    end
    src_i = '0;
  endtask

  task automatic t_write_readback();
    cfg_wr(2, 5, 1'b1, 3);
    rb_out = 3'd2; #1;
    chk(rb_en_o === 32'h20, "R2 enable mask", 64'(rb_en_o), 64'h20);
    chk(rb_sel_o === (64'd3 << 10), "R2 choice field", rb_sel_o, 64'd3 << 10);
    rb_out = 3'd3; #1;
    chk(rb_en_o === '0, "R10 other bank readback", 64'(rb_en_o), 0);
    cfg_wr(2, 5, 1'b0, 0);
    rb_out = 3'd2; #1;
    chk(rb_en_o === '0 && rb_sel_o === '0, "R2 disable write", rb_sel_o, 0);
  endtask

  task automatic t_select();
    for (int k = 0; k < 4; k++) begin
      cfg_wr(0, 3, 1'b1, k);
      src_i = '0; src_i[12 + k] = 1'b1; step();
      chk_aux("R3 chosen bit high");
      chk(aux_o[0] === 1'b1, "R3 output 0 set", 64'(aux_o), 1);
      src_i = '1; src_i[12 + k] = 1'b0; step();
      chk(aux_o[0] === 1'b0, "R3 only chosen bit matters", 64'(aux_o), 0);
    end
    cfg_wr(0, 3, 1'b0, 0);
    src_i = '0;
  endtask

  task automatic t_or();
    cfg_wr(1, 1, 1'b1, 2);
    cfg_wr(1, 30, 1'b1, 0);
    for (int p = 0; p < 4; p++) begin
      src_i = '0;
      src_i[6]   = p[0];
      src_i[120] = p[1];
      step();
      chk(aux_o[1] === (p != 0), "R4 OR of two selectors", 64'(aux_o), 64'(p != 0));
    end
    src_i = '0;
  endtask

  task automatic t_empty_and_invert();
    src_i = '1; step();
    chk(aux_o[4] === 1'b0, "R5 empty bank low", 64'(aux_o), 0);
    ctl_wr(4, 1'b1, 1'b0);
    step();
    chk(aux_o[4] === 1'b1, "R6 invert of empty bank", 64'(aux_o), 1);
    cfg_wr(4, 0, 1'b1, 0);
    step();
    chk(aux_o[4] === 1'b0, "R6 invert of high OR", 64'(aux_o), 0);
    ctl_wr(4, 1'b0, 1'b0);
    step();
    chk(aux_o[4] === 1'b1, "R6 invert cleared", 64'(aux_o), 1);
    src_i = '0;
  endtask

  task automatic t_clear();
    cfg_wr(6, 7, 1'b1, 1);
    cfg_wr(6, 9, 1'b1, 2);
    cfg_wr(7, 7, 1'b1, 1);
    ctl_wr(6, 1'b1, 1'b1);
    rb_out = 3'd6; #1;
    chk(rb_en_o === '0 && rb_sel_o === '0, "R7 bank cleared", 64'(rb_en_o), 0);
    rb_out = 3'd7; #1;
    chk(rb_en_o === 32'h80, "R7 other bank kept", 64'(rb_en_o), 64'h80);
    step();
    chk(aux_o[6] === 1'b1, "R7 invert kept with clear", 64'(aux_o), 1);
    cfg_wr(6, 2, 1'b1, 0);
    ctl_wr(6, 1'b0, 1'b0);
    rb_out = 3'd6; #1;
    chk(rb_en_o === 32'h4, "R7 clear bit not stored", 64'(rb_en_o), 64'h4);
    // same-cycle collision: clear wins
    @(negedge clk);
    cfg_we = 1'b1; cfg_out = 3'd6; cfg_mux = 5'd11; cfg_wdata = 3'b111;
    ctl_we = 1'b1; ctl_out = 3'd6; ctl_wdata = 2'b10;
    @(negedge clk);
    cfg_we = 1'b0; ctl_we = 1'b0;
    for (int m = 0; m < 32; m++) begin m_en[6][m] = 0; m_sel[6][m] = 0; end
    m_inv[6] = 0;
    #1;
    chk(rb_en_o === '0, "R7 clear beats write", 64'(rb_en_o), 0);
    ctl_wr(7, 1'b0, 1'b1);
  endtask

  task automatic t_reserved();
    cfg_wr(5, 19, 1'b1, 3);
    cfg_wr(5, 21, 1'b1, 3);
    src_i = '1; step();
    chk(aux_o[5] === 1'b0, "R8 reserved reads 0", 64'(aux_o), 0);
    cfg_wr(5, 19, 1'b1, 2);
    step();
    chk(aux_o[5] === 1'b1, "R8 neighbour passes", 64'(aux_o), 1);
    ctl_wr(5, 1'b0, 1'b1);
    src_i = '0;
  endtask

  task automatic t_latency();
    logic [7:0] old_v;
    cfg_wr(3, 16, 1'b1, 1);
    step();
    old_v = model_aux();
    src_i[65] = 1'b1;
    #1;
    chk(aux_o === old_v, "R9 no change before edge", 64'(aux_o), 64'(old_v));
    step();
    chk(aux_o[3] === 1'b1, "R9 source after one edge", 64'(aux_o), 1);
    old_v = model_aux();
    cfg_wr(3, 16, 1'b0, 1);
    chk(aux_o === old_v, "R9 config not yet on output", 64'(aux_o), 64'(old_v));
    step();
    chk(aux_o[3] === 1'b0, "R9 config after second edge", 64'(aux_o), 0);
    src_i = '0;
  endtask

  task automatic t_mixed();
    for (int i = 0; i < 40; i++) begin
      cfg_wr(int'($urandom_range(7)), int'($urandom_range(31)), 1'($urandom), int'($urandom_range(3)));
      if (i % 8 == 0) ctl_wr(int'($urandom_range(7)), 1'($urandom), 1'b0);
      src_i = {$urandom, $urandom, $urandom, $urandom};
      step();
      chk_aux("R4 R10 mixed pattern");
    end
  endtask

  initial begin
    #4_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int o = 0; o < 8; o++) begin
      m_inv[o] = 0;
      for (int m = 0; m < 32; m++) begin m_en[o][m] = 0; m_sel[o][m] = 0; end
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_write_readback();
    t_select();
    t_or();
    t_empty_and_invert();
    t_clear();
    t_reserved();
    t_latency();
    t_mixed();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule